// File: doc/BRIEF.md
# Bus Cycle Status Decoder

This block watches the three-bit status code that a processor drives at the start of every bus transfer and turns it into eight one-hot cycle-type flags. It handles two ways of forming that code. With `mode_min` low, the code arrives on three dedicated status lines. With `mode_min` high, it is built from the memory/IO select line (bit 2), the transmit/receive direction line (bit 1) and a single status line (bit 0). In both modes the all-inactive (passive) code separates one transfer from the next.

Cycle boundaries come only from the code itself. A sample that leaves the passive code opens a cycle and raises a one-clock start pulse. The type flags then hold the decoded type until the code goes back to passive, and a one-clock end pulse marks that return. A direct jump from one non-passive code to a different non-passive code breaks the protocol and raises a one-clock error pulse. The status input is not meaningful while the bus is handed to another master, or during the clocks just after reset. During those clocks the block drops its valid flag and does not use the input.

Top module: `bus_status_decoder`

## Requirements
- R1: With `mode_min` = 0, the value v on `st_code` starting a cycle sets flag bit v of `cyc_type`. The bit meanings are: 0 interrupt acknowledge, 1 I/O read, 2 I/O write, 3 halt, 4 instruction fetch, 5 memory read, 6 memory write, 7 passive (value 7 is the passive code).
- R2: With `mode_min` = 1, the passive code is 3'b011. The values map to flag bits as follows: 3'b100 to bit 0, 3'b101 to bit 1, 3'b110 to bit 2, 3'b111 to bit 3, 3'b000 to bit 4, 3'b001 to bit 5, 3'b010 to bit 6 and 3'b011 to bit 7.
- R3: `cyc_start` is high for exactly the clock after an edge at which a valid non-passive code is sampled and the previous valid sample was passive. At that same edge `cyc_type` loads the decoded type. `cyc_start` and `cyc_end` are never high together.
- R4: While a cycle is open, repeated samples of the same code leave `cyc_type` unchanged and produce no start, end or error pulse.
- R5: `cyc_end` is high for exactly the clock after an edge at which a valid passive code follows a non-passive one. At that same edge `cyc_type` becomes 8'h80 (passive flag only).
- R6: A valid sample holding a non-passive code different from the previous non-passive sample raises `proto_err` for one clock. `cyc_type` keeps its value.
- R7: A clock edge with `hold_ack` high clears `stat_valid` and `cyc_type` and gives no pulses. The next valid sample is compared against passive.
- R8: While `rst_n` is low, all outputs are 0. After `rst_n` rises, the status input is ignored for the first SYNC_STAGES+1 rising edges (default 3), and `stat_valid` is 1 after the next edge.
- R9: Whenever `stat_valid` is 1, exactly one bit of `cyc_type` is set. When `stat_valid` is 0, `cyc_type` is zero and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_min | input | 1 | 1: code built from select/direction/status lines; 0: dedicated status lines |
| st_code | input | 3 | Status code from the processor |
| hold_ack | input | 1 | Bus granted to another master; status lines floating |
| cyc_type | output | 8 | One-hot cycle type, held from start to end |
| cyc_start | output | 1 | One-clock pulse at the start of a bus cycle |
| cyc_end | output | 1 | One-clock pulse at the end of a bus cycle |
| proto_err | output | 1 | One-clock pulse on a non-passive to non-passive code change |
| stat_valid | output | 1 | Status input was sampled as meaningful at the last edge |

## Verification
The assertions assume that `hold_ack` and `st_code` are synchronous to `clk` and settle before each rising edge. They also assume that `mode_min` changes only while the code is passive under the new mode. The random stimulus drives all inputs on the falling edge. It switches the mode only between cycles and, on a switch, puts the new mode's passive code on `st_code` at the same time. It also inserts hold windows only between cycles, so every sequence the bench produces lies within what the properties assume.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned NTYPES = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [NTYPES-1:0] tvec_t;

  typedef enum logic [CODE_W-1:0] {
    CYC_INTA  = 3'd0,
    CYC_IORD  = 3'd1,
    CYC_IOWR  = 3'd2,
    CYC_HALT  = 3'd3,
    CYC_FETCH = 3'd4,
    CYC_MRD   = 3'd5,
    CYC_MWR   = 3'd6,
    CYC_IDLE  = 3'd7
  } cyc_e;

  localparam code_t CODE_IDLE = code_t'(CYC_IDLE);
  localparam tvec_t IDLE_HOT  = tvec_t'(1) << CODE_IDLE;
endpackage

// File: rtl/bsd_reset_sync.sv
module bsd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/bsd_code_norm.sv
module bsd_code_norm
  import bsd_pkg::*;
(
  input  logic  mode_min,
  input  code_t raw,
  output code_t norm,
  output tvec_t hot
);
  // The second encoding differs from the first only in the polarity of the top bit.
  assign norm = raw ^ {mode_min, {(CODE_W-1){1'b0}}};

  for (genvar i = 0; i < NTYPES; i++) begin : g_hot
    assign hot[i] = (norm == code_t'(i));
  end
endmodule

// File: rtl/bsd_track.sv
module bsd_track
  import bsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold_ack,
  input  code_t cur,
  input  tvec_t cur_hot,
  output tvec_t type_o,
  output logic  start_o,
  output logic  end_o,
  output logic  err_o,
  output logic  valid_o
);
  logic  first_q, first_d;
  code_t prev_q, prev_d;
  tvec_t type_q, type_d;
  logic  type_en;
  logic  start_q, end_q, err_q, valid_q;
  logic  smp_ok, cur_idle, prev_idle;
  logic  is_start, is_end, is_err;

  always_comb begin
    smp_ok    = !first_q && !hold_ack;
    cur_idle  = (cur == CODE_IDLE);
    prev_idle = (prev_q == CODE_IDLE);
    is_start  = smp_ok && prev_idle && !cur_idle;
    is_end    = smp_ok && !prev_idle && cur_idle;
    is_err    = smp_ok && !prev_idle && !cur_idle && (cur != prev_q);
    first_d   = 1'b0;
    prev_d    = smp_ok ? cur : CODE_IDLE;
    type_en   = !smp_ok || is_start || is_end || (type_q == '0);
    if (!smp_ok)      type_d = '0;
    else if (is_start) type_d = cur_hot;
    else              type_d = IDLE_HOT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      prev_q  <= CODE_IDLE;
      type_q  <= '0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      first_q <= first_d;
      prev_q  <= prev_d;
      if (type_en) type_q <= type_d;
      start_q <= is_start;
      end_q   <= is_end;
      err_q   <= is_err;
      valid_q <= smp_ok;
    end
  end

  assign type_o  = type_q;
  assign start_o = start_q;
  assign end_o   = end_q;
  assign err_o   = err_q;
  assign valid_o = valid_q;

  assert_type_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $countones(type_q) == 1);
  assert_quiet_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (type_q == '0) && !start_q && !end_q && !err_q);
  assert_no_start_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && end_q));
  assert_start_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !type_q[NTYPES-1] && (type_q != '0));
  assert_end_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> type_q == IDLE_HOT);
  assert_type_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(valid_q) && !start_q && !end_q) |-> $stable(type_q));
  assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |=> !valid_q);
endmodule

// File: rtl/bus_status_decoder.sv
module bus_status_decoder
  import bsd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_min,
  input  logic [CODE_W-1:0] st_code,
  input  logic              hold_ack,
  output logic [NTYPES-1:0] cyc_type,
  output logic              cyc_start,
  output logic              cyc_end,
  output logic              proto_err,
  output logic              stat_valid
);
  logic  rst_n_s;
  code_t norm;
  tvec_t hot;

  bsd_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  bsd_code_norm u_norm (
    .mode_min(mode_min),
    .raw     (st_code),
    .norm    (norm),
    .hot     (hot)
  );

  bsd_track u_trk (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .hold_ack(hold_ack),
    .cur     (norm),
    .cur_hot (hot),
    .type_o  (cyc_type),
    .start_o (cyc_start),
    .end_o   (cyc_end),
    .err_o   (proto_err),
    .valid_o (stat_valid)
  );

  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    proto_err |-> !cyc_start && !cyc_end && stat_valid);
endmodule

// File: tb/sim_bus_status_decoder.sv
`timescale 1ns/100ps
module sim_bus_status_decoder;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_min;
  logic [2:0] st_code;
  logic       hold_ack;
  logic [7:0] cyc_type;
  logic       cyc_start, cyc_end, proto_err, stat_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int         n_edge;
  logic [2:0] m_prev;
  logic [7:0] m_type;
  logic       m_start, m_end, m_err, m_valid;

  always #2.5 clk = ~clk;

  bus_status_decoder #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_min(mode_min), .st_code(st_code),
    .hold_ack(hold_ack), .cyc_type(cyc_type), .cyc_start(cyc_start),
    .cyc_end(cyc_end), .proto_err(proto_err), .stat_valid(stat_valid)
  );

  // Flag index per the tables in R1 and R2.
  function automatic logic [2:0] type_idx(input logic mm, input logic [2:0] c);
    if (!mm) return c;
    case (c)
      3'b100: return 3'd0;
      3'b101: return 3'd1;
      3'b110: return 3'd2;
      3'b111: return 3'd3;
      3'b000: return 3'd4;
      3'b001: return 3'd5;
      3'b010: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [2:0] idle_raw(input logic mm);
    return mm ? 3'b011 : 3'b111;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "cyc_type", cyc_type, m_type);
    chk(tag, "cyc_start", {7'd0, cyc_start}, {7'd0, m_start});
    chk(tag, "cyc_end", {7'd0, cyc_end}, {7'd0, m_end});
    chk(tag, "proto_err", {7'd0, proto_err}, {7'd0, m_err});
    chk(tag, "stat_valid", {7'd0, stat_valid}, {7'd0, m_valid});
  endtask

  // One clock: drive at the falling edge, model the rising edge, check at the next falling edge.
  task automatic cyc(input logic mm, input logic [2:0] c, input logic h, input string tag);
    logic [2:0] ix;
    logic ok;
    mode_min = mm; st_code = c; hold_ack = h;
    @(posedge clk);
    n_edge++;
    ix = type_idx(mm, c);
    ok = (n_edge >= SYNC + 2) && !h;
    m_start = ok && (m_prev == 3'd7) && (ix != 3'd7);
    m_end   = ok && (m_prev != 3'd7) && (ix == 3'd7);
    m_err   = ok && (m_prev != 3'd7) && (ix != 3'd7) && (ix != m_prev);
    m_valid = ok;
    if (!ok)                         m_type = 8'h00;
    else if (m_start)                m_type = 8'h01 << ix;
    else if (m_end || m_type == 0)   m_type = 8'h80;
    m_prev = ok ? ix : 3'd7;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    logic mm;
    rst_n = 1'b0; mode_min = 1'b0; st_code = 3'b111; hold_ack = 1'b0;
    n_edge = 0; m_prev = 3'd7; m_type = 8'h00;
    m_start = 0; m_end = 0; m_err = 0; m_valid = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R8");
    rst_n = 1'b1;
    // R8: non-passive code during the ignored edges must not open a cycle.
    for (int i = 0; i < SYNC + 1; i++) cyc(1'b0, 3'b000, 1'b0, "R8");
    cyc(1'b0, 3'b111, 1'b0, "R8");
    // R1 and R3/R4/R5: every code in the dedicated-line mode.
    for (int k = 0; k < 7; k++) begin
      cyc(1'b0, 3'(k), 1'b0, "R1");
      cyc(1'b0, 3'(k), 1'b0, "R4");
      cyc(1'b0, 3'b111, 1'b0, "R5");
    end
    cyc(1'b0, 3'b111, 1'b0, "R1");
    // R2: every code in the composed mode.
    cyc(1'b1, 3'b011, 1'b0, "R2");
    for (int k = 0; k < 8; k++) begin
      cyc(1'b1, 3'(k), 1'b0, "R2");
      cyc(1'b1, 3'b011, 1'b0, "R3");
    end
    // R6: direct change between non-passive codes.
    cyc(1'b1, 3'b001, 1'b0, "R6");
    cyc(1'b1, 3'b010, 1'b0, "R6");
    cyc(1'b1, 3'b010, 1'b0, "R6");
    cyc(1'b1, 3'b011, 1'b0, "R6");
    // R7: hold with a floating code, then a non-passive sample starts a cycle.
    cyc(1'b1, 3'b000, 1'b1, "R7");
    cyc(1'b1, 3'b101, 1'b1, "R7");
    cyc(1'b1, 3'b101, 1'b0, "R7");
    cyc(1'b1, 3'b011, 1'b0, "R7");
    // Random traffic.
    mm = 1'b1;
    for (int it = 0; it < 2500; it++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) begin
        mm = ~mm;
        cyc(mm, idle_raw(mm), 1'b0, "R9");
      end else if (r == 1) begin
        for (int j = 0; j <= int'($urandom % 3); j++) cyc(mm, 3'($urandom), 1'b1, "R7");
        cyc(mm, idle_raw(mm), 1'b0, "R7");
      end else begin
        logic [2:0] c;
        c = 3'($urandom);
        if (c == idle_raw(mm)) c = c ^ 3'b100;
        for (int j = 0; j <= int'($urandom % 4); j++) cyc(mm, c, 1'b0, "R9");
        if (($urandom % 8) == 0) begin
          logic [2:0] c2;
          c2 = c ^ 3'(1 + ($urandom % 3));
          if (c2 == idle_raw(mm)) c2 = c ^ 3'b100;
          cyc(mm, c2, 1'b0, "R6");
        end
        cyc(mm, idle_raw(mm), 1'b0, "R5");
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule